// File: doc/BRIEF.md
# Chunked Population Counter

This block counts the set bits in a wide data word and gives the total as a binary number. Each word can hold any bit pattern; the block does not assume the ones are contiguous. The word is cut into 4-bit slices. Each slice passes through a 16-entry table that gives its own count of ones, from 0 to 4. The slice counts then meet in a balanced binary adder tree, so the depth of the logic grows with the logarithm of the word width and not with the width itself.

Words enter on a valid/ready stream and leave on a second one. A single output register stands between the tree and the result port. A new word can be taken on every cycle as long as the consumer keeps up. Back-pressure works as follows. The input is ready whenever the output register is empty or its content is being taken in the same cycle. While a result waits with `cnt_ready` low, the result is frozen and the input stalls. With the default width of 95, the word is padded at the top with one zero to make 24 slices, and the count is 7 bits wide.

Top module: `popcount_tree`

## Requirements
- R1: While reset is asserted, and after it is released until a word is accepted, `cnt_valid` is 0 and `cnt_value` is 0.
- R2: For any accepted word, `cnt_value` equals the number of ones in `word_data`. The bit order does not matter and the ones need not be contiguous.
- R3: An all-zeros word gives a count of 0. An all-ones word gives a count equal to the word width (95 by default).
- R4: A word with exactly one bit set gives a count of 1 for every bit position 0 through width-1. The padding above the top bit never adds to the count.
- R5: A word accepted at a clock edge (`word_valid` and `word_ready` both high) shows its count, with `cnt_valid` high, right after that same edge. The latency is exactly one cycle.
- R6: `word_ready` is high exactly when `cnt_valid` is low or `cnt_ready` is high. A word can therefore be accepted on every cycle.
- R7: While `cnt_valid` is high and `cnt_ready` is low, `cnt_valid` stays high and `cnt_value` keeps its value at the next edge.
- R8: An edge with `word_ready` high and `word_valid` low leaves `cnt_valid` low after it. `cnt_value` keeps its last value.
- R9: Each 4-bit slice is mapped to its own number of ones, as a 3-bit value from 0 to 4. Examples: 0000 gives 0, 0011 gives 2, 1111 gives 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | Input word is present |
| word_ready | output | 1 | Block can take a word this cycle |
| word_data | input | DATA_W (95) | Word whose ones are counted |
| cnt_valid | output | 1 | Result register holds a count |
| cnt_ready | input | 1 | Consumer takes the count this cycle |
| cnt_value | output | CNT_W (7) | Number of ones in the accepted word |

## Verification
A wrong table entry or a bad tree connection shows up as a wrong `cnt_value` one cycle after the faulty word is accepted. The error appears only for words that use the affected slice or subtree. For that reason the single-bit sweep covers every slice position, and random words exercise the mixed patterns. A corrupted output register or handshake state shows up within one cycle in other ways: as a `cnt_valid` that does not match the stream history, as a `word_ready` that ignores the free-slot rule, or as a count that changes while the consumer stalls. The bench model predicts all three on every clock.

// File: rtl/popcount_pkg.sv
package popcount_pkg;
  // Slice geometry used by the recode table
  localparam int unsigned SLICE_W     = 4;
  localparam int unsigned SLICE_CNT_W = $clog2(SLICE_W + 1);
endpackage

// File: rtl/slice_count.sv
module slice_count
  import popcount_pkg::*;
(
  input  logic [SLICE_W-1:0]     bits,
  output logic [SLICE_CNT_W-1:0] ones
);
  // 16-entry recode of a slice into its count of ones (R9)
  always_comb begin
    unique case (bits)
      4'b0000: ones = 3'd0;
      4'b0001: ones = 3'd1;
      4'b0010: ones = 3'd1;
      4'b0011: ones = 3'd2;
      4'b0100: ones = 3'd1;
      4'b0101: ones = 3'd2;
      4'b0110: ones = 3'd2;
      4'b0111: ones = 3'd3;
      4'b1000: ones = 3'd1;
      4'b1001: ones = 3'd2;
      4'b1010: ones = 3'd2;
      4'b1011: ones = 3'd3;
      4'b1100: ones = 3'd2;
      4'b1101: ones = 3'd3;
      4'b1110: ones = 3'd3;
      default: ones = 3'd4;
    endcase
  end
endmodule

// File: rtl/add_tree.sv
module add_tree #(
  parameter  int unsigned LEAVES = 24,
  parameter  int unsigned IN_W   = 3,
  localparam int unsigned LEVELS = (LEAVES > 1) ? $clog2(LEAVES) : 0,
  localparam int unsigned SLOTS  = 1 << LEVELS,
  localparam int unsigned OUT_W  = IN_W + LEVELS
) (
  input  logic [LEAVES*IN_W-1:0] leaves_flat,
  output logic [OUT_W-1:0]       total
);
  // One stage per level; each level is one bit wider than the one below
  for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_stage
    localparam int unsigned W = IN_W + lv;
    localparam int unsigned N = SLOTS >> lv;
    logic [W-1:0] node [N];
    if (lv == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_slot
        if (i < LEAVES) begin : g_used
          assign node[i] = leaves_flat[i*IN_W +: IN_W];
        end else begin : g_pad
          assign node[i] = '0;
        end
      end
    end else begin : g_sum
      for (genvar i = 0; i < N; i++) begin : g_pair
        assign node[i] = {1'b0, g_stage[lv-1].node[2*i]}
                       + {1'b0, g_stage[lv-1].node[2*i+1]};
      end
    end
  end

  assign total = g_stage[LEVELS].node[0];
endmodule

// File: rtl/popcount_tree.sv
module popcount_tree
  import popcount_pkg::*;
#(
  parameter  int unsigned DATA_W  = 95,
  localparam int unsigned SLICES  = (DATA_W + SLICE_W - 1) / SLICE_W,
  localparam int unsigned PAD_W   = SLICES * SLICE_W,
  localparam int unsigned CNT_W   = $clog2(DATA_W + 1),
  localparam int unsigned LEVELS  = (SLICES > 1) ? $clog2(SLICES) : 0,
  localparam int unsigned TREE_W  = SLICE_CNT_W + LEVELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [DATA_W-1:0] word_data,
  output logic              cnt_valid,
  input  logic              cnt_ready,
  output logic [CNT_W-1:0]  cnt_value
);
  logic [PAD_W-1:0]              padded;
  logic [SLICES*SLICE_CNT_W-1:0] slice_cnts;
  logic [TREE_W-1:0]             tree_total;

  // Zero-extend to a whole number of slices
  always_comb begin
    padded = '0;
    padded[DATA_W-1:0] = word_data;
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    slice_count u_slice (
      .bits (padded[s*SLICE_W +: SLICE_W]),
      .ones (slice_cnts[s*SLICE_CNT_W +: SLICE_CNT_W])
    );
  end

  add_tree #(
    .LEAVES (SLICES),
    .IN_W   (SLICE_CNT_W)
  ) u_tree (
    .leaves_flat (slice_cnts),
    .total       (tree_total)
  );

  // Output slot is free when empty or being drained
  assign word_ready = !cnt_valid || cnt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_valid <= 1'b0;
      cnt_value <= '0;
    end else if (word_ready) begin
      cnt_valid <= word_valid;
      if (word_valid) cnt_value <= tree_total[CNT_W-1:0];
    end
  end

  // Per-slice table check against a direct bit count (R9)
  for (genvar s = 0; s < SLICES; s++) begin : g_lut_chk
    p_lut_r9: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (slice_cnts[s*SLICE_CNT_W +: SLICE_CNT_W]
                      == SLICE_CNT_W'($countones(padded[s*SLICE_W +: SLICE_W]))));
  end

  // Tree total never exceeds the word width (R2)
  p_tree_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (tree_total <= TREE_W'(DATA_W)));

  p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> (cnt_value <= CNT_W'(DATA_W)));

  p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> cnt_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_valid && !cnt_ready) |=> (cnt_valid && $stable(cnt_value)));

  p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && word_ready) |=> (!cnt_valid && $stable(cnt_value)));
endmodule

// File: tb/popcount_tree_bench.sv
module popcount_tree_bench;
  localparam int DATA_W = 95;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              word_valid = 1'b0;
  logic              word_ready;
  logic [DATA_W-1:0] word_data = '0;
  logic              cnt_valid;
  logic              cnt_ready = 1'b1;
  logic [CNT_W-1:0]  cnt_value;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Behavioural model state
  bit m_valid = 1'b0;
  int m_count = 0;

  always #10 clk = ~clk;

  popcount_tree #(.DATA_W(DATA_W)) u_popcount_tree (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data),
    .cnt_valid  (cnt_valid),
    .cnt_ready  (cnt_ready),
    .cnt_value  (cnt_value)
  );

  function automatic int ones_in(logic [DATA_W-1:0] w);
    int n = 0;
    for (int i = 0; i < DATA_W; i++) if (w[i]) n++;
    return n;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Model update and comparison every clock, sampled 5 ns after the edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (!m_valid || cnt_ready) begin
        m_valid = word_valid;
        if (word_valid) m_count = ones_in(word_data);
      end
    end
    #5;
    if (rst_n) begin
      check({"R5 ", cur_req, " valid"}, int'(cnt_valid), int'(m_valid));
      check("R6 ready", int'(word_ready), int'(!m_valid || cnt_ready));
      check({cur_req, " count"}, int'(cnt_value), m_count);
    end
  end

  task automatic send(logic [DATA_W-1:0] w);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = w;
    cnt_ready  = 1'b1;
  endtask

  function automatic logic [DATA_W-1:0] rand_word();
    logic [95:0] r = {$urandom, $urandom, $urandom};
    return r[DATA_W-1:0];
  endfunction

  initial begin
    // R1: reset state, during and right after reset
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(cnt_valid), 0);
    check("R1 count in reset", int'(cnt_value), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid idle", int'(cnt_valid), 0);
    check("R1 count idle", int'(cnt_value), 0);

    // R3: all-zeros and all-ones words
    cur_req = "R3";
    send('0);
    send('1);
    send('0);

    // R4: every single-bit position
    cur_req = "R4";
    for (int p = 0; p < DATA_W; p++) send(DATA_W'(1) << p);

    // R2: random words, back to back
    cur_req = "R2";
    for (int k = 0; k < 300; k++) send(rand_word());
    // R2: sparse and dense random mixes
    for (int k = 0; k < 100; k++) send(rand_word() & rand_word() & rand_word());
    for (int k = 0; k < 100; k++) send(rand_word() | rand_word() | rand_word());

    // R7: random back-pressure from the consumer
    cur_req = "R7";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!word_valid || word_ready) begin
        word_valid = ($urandom_range(0, 3) != 0);
        word_data  = rand_word();
      end
      cnt_ready = ($urandom_range(0, 2) == 0);
    end

    // R8: bubbles between words with the consumer always ready
    cur_req = "R8";
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cnt_ready  = 1'b1;
      word_valid = k[0];
      word_data  = rand_word();
    end
    @(negedge clk);
    word_valid = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule